// File: doc/BRIEF.md
# Ping-Pong Frame Hit Memory Writer

This block collects the 16-bit words that describe the rows of one frame of hit data. Each row is a header word followed by its state words. The block packs the words two at a time into 32-bit entries. An entry is made of two 16-bit single-port RAMs: the low RAM holds bits 15:0 and the high RAM holds bits 31:16. Each row begins on a fresh entry. When a row has an odd number of words, the high half of its last entry is not written and keeps whatever it held before.

There are two such RAM pairs. The incoming frame fills one pair while the readout side has random access to the other pair through a registered read port. A one-cycle frame-start pulse does four things: it swaps the roles of the two pairs, returns the write address to entry zero, clears the full condition, and captures how many entries the finished frame used. The readout side uses that count to know how far to read. When the write pair runs out of entries, further words are dropped and a full flag stays set until the next frame start.

Top module: `hit_bank_writer`

## Requirements
- R1: After reset, `wr_bank` is 0, `mem_full` is 0 and `rd_count` is 0.
- R2: Within a row, words alternate between the halves of an entry. The first word of a pair is stored in bits 15:0 and the second in bits 31:16 of the same entry. Entries are used at consecutive addresses starting from 0 in each frame.
- R3: If a row ends after a low-half word (`wr_row_end` set with that word), the next word goes to the low half of the next entry. The high half of the row's last entry is not written and keeps its earlier content.
- R4: A `frame_start` pulse toggles `wr_bank` in the following cycle. `rd_addr` always addresses the pair that is not being written (bank `~wr_bank`). `rd_data` shows that entry one clock after `rd_addr` is presented.
- R5: On `frame_start`, `rd_count` takes the number of entries touched by the finished frame, with a partly filled entry counted as one.
- R6: A word presented in the same cycle as `frame_start` is the first word of the new frame. It is stored in the low half of entry 0 of the newly selected bank.
- R7: Once all DEPTH entries of the write bank are used, `mem_full` is 1 and stays 1 until the next `frame_start`. Words arriving in that time are dropped and change no entry, and `rd_count` then reports DEPTH.
- R8: Writing a frame never changes the contents of the bank being read.
- R9: A cycle with `wr_valid` low stores nothing and does not move the address, whatever `wr_data` and `wr_row_end` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse marking the start of a new frame |
| wr_valid | input | 1 | `wr_data` carries a word this cycle |
| wr_row_end | input | 1 | The word this cycle is the last one of its row |
| wr_data | input | 16 | Incoming row word (header or state) |
| rd_addr | input | $clog2(DEPTH) | Entry address in the bank being read |
| rd_data | output | 32 | Entry read from the read bank, one cycle after `rd_addr` |
| rd_count | output | $clog2(DEPTH)+1 | Entries used by the most recently completed frame |
| wr_bank | output | 1 | Index of the bank currently being written |
| mem_full | output | 1 | Write bank exhausted; words are being dropped |

## Verification
A word driven in one cycle lands in its RAM at the next rising edge. Its value can be seen only after the banks swap: `rd_addr` is then driven, and `rd_data` is sampled one edge later on the following falling edge. `frame_start` updates `wr_bank`, `rd_count` and `mem_full` at the same edge that accepts it, so these outputs are sampled on the falling edge right after the pulse. The bench changes inputs only on falling edges and compares every output half a period after the edge that should have produced it. It sweeps every entry of the read bank after each frame and checks each half whose content is known.

// File: rtl/hbw_pkg.sv
// Shared types for the ping-pong hit memory writer.
package hbw_pkg;
    // Which half of the current entry receives the next word.
    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;
endpackage

// File: rtl/hbw_half_ram.sv
// Single-port 16-bit RAM slice, one half of a 32-bit entry.
// Assumes: one access per cycle; the read is registered and returns the
// old content when a write hits the same address (read-first).
module hbw_half_ram #(
    parameter int DEPTH = 2048,
    parameter int WIDTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Storage write and registered read on the single port.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        rdata <= mem[addr];
    end
endmodule

// File: rtl/hbw_wr_ctrl.sv
// Write-side sequencer: address counter, half pairing, full flag, bank
// select and frame entry count.
// Assumes: frame_start is a single-cycle pulse; a word arriving with
// frame_start belongs to the new frame.
module hbw_wr_ctrl
    import hbw_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          wr_valid,
    input  logic          wr_row_end,
    output logic          we_lo,
    output logic          we_hi,
    output logic [AW-1:0] wr_addr,
    output logic          wr_sel,
    output logic          bank_q,
    output logic          full_q,
    output logic [AW:0]   count_q
);
    localparam logic [AW:0] LAST_ENTRY = (AW+1)'(DEPTH - 1);

    logic [AW:0] addr_q, addr_d, base_addr;
    half_e       half_q, half_d, base_half;
    logic        full_d, base_full, accept, advance;

    // Next-state for the address, half and full flag; frame start clears first.
    always_comb begin
        base_addr = frame_start ? '0 : addr_q;
        base_half = frame_start ? HALF_LO : half_q;
        base_full = frame_start ? 1'b0 : full_q;
        accept    = wr_valid && !base_full;
        we_lo     = accept && (base_half == HALF_LO);
        we_hi     = accept && (base_half == HALF_HI);
        advance   = accept && ((base_half == HALF_HI) || wr_row_end);
        addr_d    = advance ? base_addr + 1'b1 : base_addr;
        if (accept) begin
            half_d = ((base_half == HALF_LO) && !wr_row_end) ? HALF_HI : HALF_LO;
        end else begin
            half_d = base_half;
        end
        full_d    = base_full || (advance && (base_addr == LAST_ENTRY));
        wr_addr   = base_addr[AW-1:0];
        wr_sel    = frame_start ? ~bank_q : bank_q;
    end

    // Sequencer state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            half_q <= HALF_LO;
            full_q <= 1'b0;
            bank_q <= 1'b0;
        end else begin
            addr_q <= addr_d;
            half_q <= half_d;
            full_q <= full_d;
            bank_q <= wr_sel;
        end
    end

    // Capture of the finished frame's entry count, a partial entry included.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (frame_start) begin
            count_q <= addr_q + {{AW{1'b0}}, (half_q == HALF_HI)};
        end
    end

    // R7
    addr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_q <= (AW+1)'(DEPTH));
    // R7
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && !frame_start) |=> (full_q && $stable(addr_q)));
    // R4
    bank_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (bank_q != $past(bank_q)));
    // R6
    frame_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (addr_q <= (AW+1)'(1)));
    // R3
    row_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_row_end && !full_q && !frame_start) |=> (half_q == HALF_LO));
    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_valid && !frame_start) |=> ($stable(addr_q) && $stable(half_q)));
endmodule

// File: rtl/hit_bank_writer.sv
// Ping-pong frame hit memory writer: two banks, each a pair of 16-bit RAMs.
// The bank selected by wr_bank takes incoming words; the other bank serves
// random reads with one cycle of latency.
// Assumes: rd_addr targets only the bank not being written.
module hit_bank_writer #(
    parameter int DEPTH = 2048,
    parameter int WORD_W = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              wr_valid,
    input  logic              wr_row_end,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [2*WORD_W-1:0] rd_data,
    output logic [AW:0]       rd_count,
    output logic              wr_bank,
    output logic              mem_full
);
    logic          we_lo, we_hi, wr_sel, rd_sel_q;
    logic [AW-1:0] wr_addr;
    logic [3:0]    ram_we;
    logic [WORD_W-1:0] ram_q [2][2];

    hbw_wr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .wr_valid   (wr_valid),
        .wr_row_end (wr_row_end),
        .we_lo      (we_lo),
        .we_hi      (we_hi),
        .wr_addr    (wr_addr),
        .wr_sel     (wr_sel),
        .bank_q     (wr_bank),
        .full_q     (mem_full),
        .count_q    (rd_count)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        for (genvar h = 0; h < 2; h++) begin : g_half
            logic          we_i;
            logic [AW-1:0] addr_i;
            // Port steering: write bank takes the write address, other bank the read address.
            always_comb begin
                we_i   = (wr_sel == 1'(b)) && ((h == 0) ? we_lo : we_hi);
                addr_i = (wr_sel == 1'(b)) ? wr_addr : rd_addr;
            end
            assign ram_we[2*b+h] = we_i;
            hbw_half_ram #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_ram (
                .clk  (clk),
                .we   (we_i),
                .addr (addr_i),
                .wdata(wr_data),
                .rdata(ram_q[b][h])
            );
        end
    end

    // Remember which bank served the read so its output is picked next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_sel_q <= 1'b1;
        end else begin
            rd_sel_q <= ~wr_sel;
        end
    end

    // Read data assembly from the selected bank's two halves.
    always_comb begin
        rd_data = {ram_q[rd_sel_q][1], ram_q[rd_sel_q][0]};
    end

    // R8
    one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ram_we));
    // R8
    read_bank_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |-> (ram_we[{~wr_bank, 1'b0}] == 1'b0 && ram_we[{~wr_bank, 1'b1}] == 1'b0));
endmodule

// File: tb/hit_bank_writer_bench.sv
// Bench: small depth, model-based sweep of every entry after each frame.
module hit_bank_writer_bench;
    localparam int CLK_P = 10;
    localparam int DEPTH = 8;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic          wr_valid = 1'b0;
    logic          wr_row_end = 1'b0;
    logic [15:0]   wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0]   rd_data;
    logic [AW:0]   rd_count;
    logic          wr_bank, mem_full;

    int errors = 0;
    int checks = 0;

    // Bench-side expectation
    logic [15:0] exp_lo [2][DEPTH];
    logic [15:0] exp_hi [2][DEPTH];
    bit          kn_lo  [2][DEPTH];
    bit          kn_hi  [2][DEPTH];
    int          m_addr = 0;
    bit          m_half = 0;
    bit          m_full = 0;
    bit          m_bank = 0;
    int          m_count = 0;

    hit_bank_writer #(.DEPTH(DEPTH)) u_hit_bank_writer (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .wr_valid(wr_valid), .wr_row_end(wr_row_end), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_count(rd_count),
        .wr_bank(wr_bank), .mem_full(mem_full)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_word(input logic [15:0] w, input bit re);
        if (!m_full) begin
            if (!m_half) begin
                exp_lo[m_bank][m_addr] = w;
                kn_lo[m_bank][m_addr] = 1;
                if (re) m_addr++; else m_half = 1;
            end else begin
                exp_hi[m_bank][m_addr] = w;
                kn_hi[m_bank][m_addr] = 1;
                m_addr++;
                m_half = 0;
            end
            if (m_addr == DEPTH) m_full = 1;
        end
    endtask

    // One cycle carrying a word (called at a falling edge).
    task automatic send(input logic [15:0] w, input bit re);
        frame_start = 0; wr_valid = 1; wr_data = w; wr_row_end = re;
        model_word(w, re);
        @(negedge clk);
    endtask

    task automatic idle(input logic [15:0] junk);
        frame_start = 0; wr_valid = 0; wr_data = junk; wr_row_end = junk[0];
        @(negedge clk);
    endtask

    // Frame start, optionally carrying the new frame's first word.
    task automatic start_frame(input bit with_word, input logic [15:0] w, input bit re);
        m_count = m_addr + int'(m_half);
        m_bank ^= 1; m_addr = 0; m_half = 0; m_full = 0;
        frame_start = 1; wr_valid = with_word; wr_data = w; wr_row_end = re;
        if (with_word) model_word(w, re);
        @(negedge clk);
        frame_start = 0; wr_valid = 0;
        chk(wr_bank == m_bank, "R4 bank toggle", wr_bank, m_bank);
        chk(rd_count == (AW+1)'(m_count), "R5 frame entry count", rd_count, m_count);
        chk(mem_full == m_full, "R7 full cleared at frame start", mem_full, m_full);
    endtask

    // Read every entry of the read bank and compare the known halves.
    task automatic sweep(input string req);
        for (int a = 0; a < DEPTH; a++) begin
            bit rb;
            rb = ~m_bank;
            rd_addr = AW'(a);
            wr_valid = 0; frame_start = 0;
            @(negedge clk);
            if (kn_lo[rb][a])
                chk(rd_data[15:0] == exp_lo[rb][a], req, rd_data[15:0], exp_lo[rb][a]);
            if (kn_hi[rb][a])
                chk(rd_data[31:16] == exp_hi[rb][a], req, rd_data[31:16], exp_hi[rb][a]);
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int b = 0; b < 2; b++)
            for (int a = 0; a < DEPTH; a++) begin
                kn_lo[b][a] = 0; kn_hi[b][a] = 0;
            end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk(wr_bank == 0, "R1 wr_bank", wr_bank, 0);
        chk(mem_full == 0, "R1 mem_full", mem_full, 0);
        chk(rd_count == 0, "R1 rd_count", rd_count, 0);

        // Frame 0 into bank 0: rows of 3, 2 and 1 words with idle gaps (R2 R3 R9)
        send(16'h1000, 0); send(16'h1001, 0); send(16'h1002, 1);
        idle(16'hDEAD); idle(16'hBEEF);
        send(16'h1003, 0); send(16'h1004, 1);
        idle(16'h5555);
        send(16'h1005, 1);
        chk(mem_full == 0, "R7 not full", mem_full, 0);
        start_frame(0, 16'h0, 0);          // R5 count 4
        sweep("R2 R3 R9 frame0 contents");

        // Frame 1 into bank 1: rows of 4 until full, then extra words dropped (R7)
        for (int i = 0; i < 20; i++) begin
            send(16'h2000 + 16'(i), (i % 4) == 3);
            if (i == 15) chk(mem_full == 1, "R7 full after last entry", mem_full, 1);
        end
        chk(mem_full == 1, "R7 full held", mem_full, 1);
        idle(16'h0);
        chk(mem_full == 1, "R7 full held idle", mem_full, 1);
        start_frame(1, 16'h3000, 1);       // R6 word with frame start, R5 count DEPTH
        sweep("R7 R2 frame1 contents");

        // Frame 2 into bank 0 over frame 0 data: entry 0 high keeps 1001 (R3 R6)
        send(16'h3001, 0); send(16'h3002, 1);
        send(16'h3003, 1);
        start_frame(0, 16'h0, 0);
        sweep("R3 R6 R8 frame2 contents");

        // Frame 3 into bank 1 while bank 0 stays intact (R8)
        send(16'h4000, 0); send(16'h4001, 0); send(16'h4002, 0);
        idle(16'h1234);
        rd_addr = '0;
        @(negedge clk);
        chk(rd_data == {exp_hi[0][0], exp_lo[0][0]}, "R8 read bank stable during writes",
            rd_data, {exp_hi[0][0], exp_lo[0][0]});
        start_frame(0, 16'h0, 0);          // R5 partial entry counted: 2
        sweep("R2 R8 frame3 contents");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule